// File: doc/BRIEF.md
# Reorder Buffer with Speculative Register File

This block keeps instruction results in program order for an out-of-order core whose adder and multiplier units finish out of order. Each instruction that leaves decode gets one slot in a circular queue. The slot holds a valid bit, its tag (the slot index), the opcode, the destination register, the result value, a ready bit and an exception bit. In the same cycle, the instruction's destination register is renamed in a speculative register file. A renamed slot drops its valid bit and records the tag of the instruction that will produce it.

Result broadcasts arrive on two ports, and both ports may be active in the same cycle. A broadcast marks its queue slot ready. It also writes the speculative register slot that is still waiting on that tag.

The oldest slot retires when it is ready and carries no exception, one per cycle, and its value goes into the architectural register file. If the oldest slot is ready and flagged, nothing retires. The whole queue is discarded, and every speculative register is reloaded from the architectural file. A multiply result is always treated as exceptional.

Top module: `rob_ff_top`

## Requirements
- R1: After reset the queue is empty and `alloc_ready` is 1. `retire_valid` and `flush` are 0. Every speculative register reads valid with data 0, and every architectural register reads 0.
- R2: An instruction is accepted on a rising edge where `alloc_valid` and `alloc_ready` are both 1. `alloc_op` is 0 for ADD and 1 for MUL. `alloc_tag` shows the tag the accepted instruction receives. Tags are handed out in ascending order from 0 and wrap from 7 to 0.
- R3: Accepting an instruction renames its destination register. From the next cycle, that speculative register reads invalid and its tag equals the allocated tag.
- R4: Each broadcast port b carries a tag in bits [3b+2:3b] of `bc_tag` and data in bits [32b+31:32b] of `bc_data`. A broadcast marks the matching queue slot ready. It writes a speculative register only if that register is invalid and its tag equals the broadcast tag. Both ports may be used in the same cycle.
- R5: Retirement follows allocation order, whatever the order of the broadcasts. In each cycle where the oldest slot is ready and not flagged, `retire_valid` is 1 and `retire_rd`/`retire_data` show that slot. The architectural register is updated at the following edge.
- R6: When the oldest slot is ready and flagged, `flush` is 1 for one cycle and `retire_valid` is 0. At the next edge all slots are dropped and every speculative register becomes valid with its architectural value. The next allocated tag is then 0. A flagged slot that is not the oldest causes nothing.
- R7: A MUL slot that receives its result is always flagged, even when `bc_excp` is 0.
- R8: A rename and a matching broadcast to the same register in the same cycle leave the register invalid, with the new tag.
- R9: When 8 instructions are in flight, or while `flush` is 1, `alloc_ready` is 0. An `alloc_valid` pulse in that state changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Decode offers an instruction |
| alloc_op | input | 1 | 0 = ADD, 1 = MUL |
| alloc_rd | input | 3 | Destination register |
| alloc_ready | output | 1 | Queue can accept an instruction |
| alloc_tag | output | 3 | Tag given to the offered instruction |
| bc_valid | input | 2 | Broadcast port valid bits |
| bc_tag | input | 6 | Broadcast tags, 3 bits per port |
| bc_data | input | 64 | Broadcast data, 32 bits per port |
| bc_excp | input | 2 | Broadcast exception flags |
| retire_valid | output | 1 | Oldest slot retires this cycle |
| retire_rd | output | 3 | Register written by the retiring slot |
| retire_data | output | 32 | Value written by the retiring slot |
| flush | output | 1 | Oldest slot is exceptional; queue is discarded |
| rd_sel | input | 3 | Register selected for inspection |
| ff_valid | output | 1 | Speculative register valid bit |
| ff_tag | output | 3 | Speculative register producer tag |
| ff_data | output | 32 | Speculative register value |
| arch_data | output | 32 | Architectural register value |

## Verification
The embedded assertions check, on every cycle, these properties:
- the occupancy never exceeds the depth;
- an accepted instruction lands in an empty, not-yet-ready slot;
- a retirement advances the head by exactly one;
- a flush leaves the queue empty and every speculative register valid;
- a rename leaves the register waiting on the new tag.

Only the scenarios can show the following:
- results broadcast out of order still retire in allocation order with the right values;
- a stale broadcast is kept out of a re-renamed register;
- a multiply aborts the stream even with a clean flag;
- a flagged slot that is not the oldest waits its turn;
- the registers after a flush equal the architectural ones.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int DW    = 32;
    localparam int NREG  = 8;
    localparam int DEPTH = 8;
    localparam int NB    = 2;
    localparam int RW    = $clog2(NREG);
    localparam int TW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    typedef enum logic {OP_ADD = 1'b0, OP_MUL = 1'b1} op_e;

    typedef struct packed {
        logic          valid;
        logic [TW-1:0] tag;
        op_e           op;
        logic [RW-1:0] rd;
        logic [DW-1:0] value;
        logic          ready;
        logic          excp;
    } rob_ent_t;

    typedef struct packed {
        logic          valid;
        logic [TW-1:0] tag;
        logic [DW-1:0] data;
    } ff_ent_t;

    typedef struct packed {
        logic          valid;
        logic [TW-1:0] tag;
        logic [DW-1:0] data;
        logic          excp;
    } bcast_t;

    function automatic logic [TW-1:0] tag_inc(input logic [TW-1:0] t);
        return (t == TW'(DEPTH - 1)) ? '0 : t + 1'b1;
    endfunction
endpackage

// File: rtl/arch_regs.sv
module arch_regs
    import rob_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_rd,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] vals [NREG]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) vals[r] <= '0;
        end else if (wr_en) begin
            vals[wr_rd] <= wr_data;
        end
    end
endmodule

// File: rtl/spec_regs.sv
module spec_regs
    import rob_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          rename,
    input  logic [RW-1:0] rn_rd,
    input  logic [TW-1:0] rn_tag,
    input  bcast_t        bc [NB],
    input  logic [DW-1:0] arch_vals [NREG],
    output ff_ent_t       slots [NREG]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) slots[r] <= '{valid: 1'b1, tag: '0, data: '0};
        end else if (flush) begin
            for (int r = 0; r < NREG; r++) slots[r] <= '{valid: 1'b1, tag: '0, data: arch_vals[r]};
        end else begin
            for (int r = 0; r < NREG; r++) begin
                for (int b = 0; b < NB; b++) begin
                    if (bc[b].valid && !slots[r].valid && slots[r].tag == bc[b].tag) begin
                        slots[r].valid <= 1'b1;
                        slots[r].data  <= bc[b].data;
                    end
                end
                // a younger rename overrides any broadcast in the same cycle
                if (rename && rn_rd == RW'(r)) begin
                    slots[r].valid <= 1'b0;
                    slots[r].tag   <= rn_tag;
                end
            end
        end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_chk
        a_r3_rename_waits: assert property (@(posedge clk) disable iff (rst)
            (rename && !flush && rn_rd == RW'(r)) |=> (!slots[r].valid && slots[r].tag == $past(rn_tag)));
        a_r6_reload_valid: assert property (@(posedge clk) disable iff (rst)
            flush |=> slots[r].valid);
    end
endmodule

// File: rtl/rob_queue.sv
module rob_queue
    import rob_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_fire,
    input  op_e           alloc_op,
    input  logic [RW-1:0] alloc_rd,
    input  bcast_t        bc [NB],
    input  logic          retire,
    input  logic          flush,
    output logic [TW-1:0] tail,
    output logic [CW-1:0] count,
    output rob_ent_t      head_ent
);
    rob_ent_t      ents [DEPTH];
    logic [TW-1:0] head;

    assign head_ent = ents[head];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (bc[b].valid && ents[bc[b].tag].valid && !ents[bc[b].tag].ready) begin
                    ents[bc[b].tag].value <= bc[b].data;
                    ents[bc[b].tag].ready <= 1'b1;
                    ents[bc[b].tag].excp  <= bc[b].excp || (ents[bc[b].tag].op == OP_MUL);
                end
            end
            if (retire) begin
                ents[head].valid <= 1'b0;
                head <= tag_inc(head);
            end
            if (alloc_fire) begin
                ents[tail] <= '{valid: 1'b1, tag: tail, op: alloc_op, rd: alloc_rd,
                               value: '0, ready: 1'b0, excp: 1'b0};
                tail <= tag_inc(tail);
            end
            count <= count + CW'(alloc_fire) - CW'(retire);
        end
    end

    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    a_r2_alloc_slot: assert property (@(posedge clk) disable iff (rst)
        (alloc_fire && !flush) |=> (ents[$past(tail)].valid && !ents[$past(tail)].ready));
    a_r5_head_step: assert property (@(posedge clk) disable iff (rst)
        (retire && !flush) |=> head == tag_inc($past(head)));
    a_r6_flush_empty: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0 && tail == '0));
endmodule

// File: rtl/rob_ff_top.sv
module rob_ff_top
    import rob_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_valid,
    input  logic             alloc_op,
    input  logic [RW-1:0]    alloc_rd,
    output logic             alloc_ready,
    output logic [TW-1:0]    alloc_tag,
    input  logic [NB-1:0]    bc_valid,
    input  logic [NB*TW-1:0] bc_tag,
    input  logic [NB*DW-1:0] bc_data,
    input  logic [NB-1:0]    bc_excp,
    output logic             retire_valid,
    output logic [RW-1:0]    retire_rd,
    output logic [DW-1:0]    retire_data,
    output logic             flush,
    input  logic [RW-1:0]    rd_sel,
    output logic             ff_valid,
    output logic [TW-1:0]    ff_tag,
    output logic [DW-1:0]    ff_data,
    output logic [DW-1:0]    arch_data
);
    bcast_t        bc [NB];
    rob_ent_t      head_ent;
    logic [CW-1:0] count;
    logic          alloc_fire;
    logic [DW-1:0] arch_vals [NREG];
    ff_ent_t       slots [NREG];

    for (genvar b = 0; b < NB; b++) begin : g_bc
        assign bc[b] = '{valid: bc_valid[b], tag: bc_tag[b*TW +: TW],
                         data: bc_data[b*DW +: DW], excp: bc_excp[b]};
    end

    assign flush        = head_ent.valid && head_ent.ready && head_ent.excp;
    assign retire_valid = head_ent.valid && head_ent.ready && !head_ent.excp;
    assign retire_rd    = head_ent.rd;
    assign retire_data  = head_ent.value;
    assign alloc_ready  = (count != CW'(DEPTH)) && !flush;
    assign alloc_fire   = alloc_valid && alloc_ready;

    rob_queue u_queue (
        .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .alloc_op(op_e'(alloc_op)),
        .alloc_rd(alloc_rd), .bc(bc), .retire(retire_valid), .flush(flush),
        .tail(alloc_tag), .count(count), .head_ent(head_ent)
    );

    spec_regs u_spec (
        .clk(clk), .rst(rst), .flush(flush), .rename(alloc_fire), .rn_rd(alloc_rd),
        .rn_tag(alloc_tag), .bc(bc), .arch_vals(arch_vals), .slots(slots)
    );

    arch_regs u_arch (
        .clk(clk), .rst(rst), .wr_en(retire_valid), .wr_rd(retire_rd),
        .wr_data(retire_data), .vals(arch_vals)
    );

    assign ff_valid  = slots[rd_sel].valid;
    assign ff_tag    = slots[rd_sel].tag;
    assign ff_data   = slots[rd_sel].data;
    assign arch_data = arch_vals[rd_sel];

    a_r6_no_retire_on_flush: assert property (@(posedge clk) disable iff (rst)
        flush |=> !retire_valid);
endmodule

// File: tb/sim_rob_ff_top.sv
module sim_rob_ff_top;
    import rob_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             alloc_valid, alloc_op;
    logic [RW-1:0]    alloc_rd;
    logic             alloc_ready;
    logic [TW-1:0]    alloc_tag;
    logic [NB-1:0]    bc_valid;
    logic [NB*TW-1:0] bc_tag;
    logic [NB*DW-1:0] bc_data;
    logic [NB-1:0]    bc_excp;
    logic             retire_valid, flush;
    logic [RW-1:0]    retire_rd;
    logic [DW-1:0]    retire_data;
    logic [RW-1:0]    rd_sel;
    logic             ff_valid;
    logic [TW-1:0]    ff_tag;
    logic [DW-1:0]    ff_data, arch_data;

    always #2.5 clk = ~clk;

    rob_ff_top u0 (
        .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_op(alloc_op),
        .alloc_rd(alloc_rd), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data), .bc_excp(bc_excp),
        .retire_valid(retire_valid), .retire_rd(retire_rd), .retire_data(retire_data),
        .flush(flush), .rd_sel(rd_sel), .ff_valid(ff_valid), .ff_tag(ff_tag),
        .ff_data(ff_data), .arch_data(arch_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [RW+DW-1:0] exp_q [$];
    int exp_flush = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (retire_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected retire rd", longint'(retire_rd), -1);
                end else begin
                    logic [RW+DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(retire_rd == e[RW+DW-1:DW], "R5", "retire rd",
                        longint'(retire_rd), longint'(e[RW+DW-1:DW]));
                    chk(retire_data == e[DW-1:0], "R5", "retire data",
                        longint'(retire_data), longint'(e[DW-1:0]));
                end
            end
            if (flush) begin
                chk(exp_flush > 0, "R6", "unexpected flush", 1, 0);
                if (exp_flush > 0) exp_flush--;
            end
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic alloc(input logic op, input logic [RW-1:0] rd, output logic [TW-1:0] tag);
        alloc_valid = 1'b1; alloc_op = op; alloc_rd = rd;
        tag = alloc_tag;
        step();
        alloc_valid = 1'b0;
    endtask

    task automatic set_bc(input int p, input logic [TW-1:0] t, input logic [DW-1:0] d,
                          input logic x);
        bc_valid[p] = 1'b1;
        bc_tag[p*TW +: TW] = t;
        bc_data[p*DW +: DW] = d;
        bc_excp[p] = x;
    endtask

    task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] d, input logic x);
        set_bc(0, t, d, x);
        step();
        bc_valid = '0;
    endtask

    task automatic peek(input logic [RW-1:0] r);
        rd_sel = r;
        @(negedge clk);
    endtask

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] t;
        rst = 1'b1; alloc_valid = 0; alloc_op = 0; alloc_rd = 0;
        bc_valid = 0; bc_tag = 0; bc_data = 0; bc_excp = 0; rd_sel = 0;
        step(3);
        rst = 1'b0;
        step();
        // R1 reset state
        peek(3);
        chk(alloc_ready == 1'b1, "R1", "alloc_ready", alloc_ready, 1);
        chk(retire_valid == 1'b0 && flush == 1'b0, "R1", "retire/flush", retire_valid | flush, 0);
        chk(ff_valid == 1'b1 && ff_data == 0, "R1", "spec r3", ff_data, 0);
        chk(arch_data == 0, "R1", "arch r3", arch_data, 0);
        step();

        // R2 tags in order, R3 rename
        alloc(0, 1, t); chk(t == 0, "R2", "tag a", t, 0);
        alloc(0, 2, t); chk(t == 1, "R2", "tag b", t, 1);
        alloc(0, 1, t); chk(t == 2, "R2", "tag c", t, 2);
        peek(1);
        chk(ff_valid == 0 && ff_tag == 2, "R3", "r1 tag", ff_tag, 2);
        step();
        // R4 out-of-order result, no retire while head waits
        bcast(1, 22, 0);
        step();
        peek(2);
        chk(ff_valid == 1 && ff_data == 22, "R4", "r2 data", ff_data, 22);
        chk(retire_valid == 0, "R5", "head not ready", retire_valid, 0);
        step();
        // R4 two ports at once; stale tag0 kept out of r1
        exp_q.push_back({3'd1, 32'd11});
        exp_q.push_back({3'd2, 32'd22});
        exp_q.push_back({3'd1, 32'd33});
        set_bc(0, 0, 11, 0);
        set_bc(1, 2, 33, 0);
        step();
        bc_valid = '0;
        peek(1);
        chk(ff_valid == 1 && ff_data == 33, "R4", "r1 younger data", ff_data, 33);
        step(5);
        peek(1);
        chk(arch_data == 33, "R5", "arch r1", arch_data, 33);
        peek(2);
        chk(arch_data == 22, "R5", "arch r2", arch_data, 22);
        step();

        // R9 fill queue: tags 3..7,0,1,2
        for (int i = 0; i < DEPTH; i++) alloc(0, 4, t);
        chk(t == 2, "R2", "wrapped tag", t, 2);
        peek(0);
        chk(alloc_ready == 0, "R9", "full ready", alloc_ready, 0);
        step();
        alloc(0, 5, t);
        peek(5);
        chk(ff_valid == 1, "R9", "r5 not renamed", ff_valid, 1);
        chk(alloc_ready == 0, "R9", "still full", alloc_ready, 0);
        step();
        // R6 flagged non-head waits; flagged head flushes
        bcast(4, 44, 1);
        step(2);
        chk(flush == 0, "R6", "non-head flag", flush, 0);
        exp_flush = 1;
        bcast(3, 5, 1);
        step(3);
        peek(4);
        chk(ff_valid == 1 && ff_data == 0, "R6", "r4 reloaded", ff_data, 0);
        chk(alloc_ready == 1, "R6", "ready after flush", alloc_ready, 1);
        peek(1);
        chk(ff_valid == 1 && ff_data == 33, "R6", "r1 reloaded", ff_data, 33);
        step();

        // R7 multiply flags itself
        alloc(1, 5, t); chk(t == 0, "R6", "tag after flush", t, 0);
        alloc(0, 6, t);
        exp_flush = 1;
        set_bc(0, 0, 7, 0);
        set_bc(1, 1, 5, 0);
        step();
        bc_valid = '0;
        step(3);
        peek(6);
        chk(arch_data == 0, "R7", "r6 not retired", arch_data, 0);
        chk(ff_valid == 1 && ff_data == 0, "R7", "r6 reloaded", ff_data, 0);
        step();

        // R8 rename beats same-cycle broadcast
        alloc(0, 7, t);
        exp_q.push_back({3'd7, 32'd9});
        set_bc(0, t, 9, 0);
        alloc(0, 7, t);
        bc_valid = '0;
        chk(t == 1, "R8", "second tag", t, 1);
        peek(7);
        chk(ff_valid == 0 && ff_tag == 1, "R8", "r7 waits", ff_tag, 1);
        step();
        exp_q.push_back({3'd7, 32'd10});
        bcast(1, 10, 0);
        step(4);
        peek(7);
        chk(ff_valid == 1 && ff_data == 10, "R8", "r7 spec", ff_data, 10);
        chk(arch_data == 10, "R5", "arch r7", arch_data, 10);
        chk(exp_q.size() == 0, "R5", "pending retires", exp_q.size(), 0);
        chk(exp_flush == 0, "R6", "pending flushes", exp_flush, 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule